// File: doc/BRIEF.md
# Daisy-Chain Bus Arbiter

This block decides which of `NDEV` bus masters may drive a shared bus. The grant travels through a chain of device stages. The request inputs from all masters are ORed onto one line, and the central controller sees only that line. When the bus is free and the combined request is high, the controller drives a single grant into stage 0. A stage whose master is requesting keeps the grant. A stage whose master is not requesting passes it to the next stage. Priority therefore comes only from position in the chain: index 0 is the strongest and index `NDEV-1` the weakest.

The master that took the grant holds the bus until it pulses its release input. No other master can take the bus during that tenure, whatever its priority. After the release, the bus stays quiet for a settling cycle, and then the controller looks at the combined request again. The scheme is deliberately unfair: a master near the tail can wait forever while masters nearer the head keep asking. `NDEV` may be set from 2 to 16.

Top module: `chain_grant_arbiter`

## Requirements
- R1: At most one bit of `gnt_o` is high in any cycle.
- R2: When a grant is issued, it goes to the lowest-index master whose `req_i` bit is high in the issue cycle (bit 0 is the highest priority). This includes index `NDEV-1` when it is the only requester.
- R3: On an idle bus, a request present before clock edge k is sampled at edge k. The grant appears at edge k+1, not earlier.
- R4: While a master owns the bus, `gnt_o` does not change unless that owner releases. Requests from other masters, including higher-priority ones, have no effect, and neither does the owner dropping its own request.
- R5: A `rel_i` pulse from a master that does not own the bus has no effect. The owner keeps `gnt_o` and `busy_o` stays high.
- R6: The owner's release is sampled at edge e, and `gnt_o` is all zero after edge e. The combined request is first sampled again at edge e+2, so the earliest new grant appears after edge e+3.
- R7: `busy_o` is high in every cycle in which `gnt_o` is non-zero and in the one cycle after the owner's release. In all other cycles it is low.
- R8: If the request that started an issue has been withdrawn by the issue cycle, the grant runs off the tail of the chain. No master is granted and the bus returns to idle with `busy_o` low.
- R9: There is no fairness. While master 0 keeps requesting and releasing, a requesting master `NDEV-1` never receives the grant.
- R10: During and directly after reset, `gnt_o` is zero and `busy_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_i | input | NDEV | Per-master bus request, bit 0 highest priority |
| rel_i | input | NDEV | Per-master release pulse; only the owner's bit counts |
| gnt_o | output | NDEV | Per-master ownership grant, at most one bit high |
| busy_o | output | 1 | Bus-occupied status |

## Verification
Two events can land in the same cycle. One is a higher-priority master raising its request while a lower one owns the bus. The other is a non-owner pulsing release while the owner is still active. The bench provokes both during master 2's tenure and requires the grant vector to stay exactly as it was. Release from the owner can also coincide with a new request pattern. In that case the bench sets the new requesters on the same clock as the release and expects the winner three edges later, chosen by chain position alone. A scoreboard queue holds the expected winner of each tenure. It is compared whenever a new grant appears, so a grant that is missing, extra or misrouted leaves the queue out of step.

// File: rtl/dca_pkg.sv
package dca_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ISSUE = 2'd1,
    ST_OWN   = 2'd2,
    ST_GAP   = 2'd3
  } dca_state_e;

  localparam int unsigned DCA_MAX_DEV = 16;

  // Keep only the least significant set bit of a request word.
  function automatic logic [DCA_MAX_DEV-1:0] keep_lowest(
    input logic [DCA_MAX_DEV-1:0] v
  );
    return v & (~v + {{(DCA_MAX_DEV-1){1'b0}}, 1'b1});
  endfunction

  // True when the state holds the bus for a master or its trailing gap.
  function automatic logic occupies_bus(input dca_state_e s);
    return (s == ST_OWN) || (s == ST_GAP);
  endfunction

endpackage

// File: rtl/dca_stage.sv
module dca_stage (
  input  logic grant_in,
  input  logic want,
  output logic take,
  output logic grant_out
);
  // A requesting stage absorbs the grant, otherwise it is forwarded.
  assign take      = grant_in & want;
  assign grant_out = grant_in & ~want;
endmodule

// File: rtl/dca_chain.sv
module dca_chain #(
  parameter int unsigned NDEV = 4
) (
  input  logic            head,
  input  logic [NDEV-1:0] want,
  output logic [NDEV-1:0] take,
  output logic            tail
);
  logic [NDEV:0] link;

  assign link[0] = head;

  for (genvar i = 0; i < NDEV; i++) begin : g_stage
    dca_stage u_stage (
      .grant_in  (link[i]),
      .want      (want[i]),
      .take      (take[i]),
      .grant_out (link[i+1])
    );
  end

  assign tail = link[NDEV];
endmodule

// File: rtl/dca_ctrl.sv
module dca_ctrl
  import dca_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic any_req,
  input  logic took,
  input  logic rel_hit,
  output logic head,
  output logic busy,
  output logic evt_drop,
  output logic evt_release
);
  dca_state_e state, nxt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= ST_IDLE;
    else        state <= nxt;
  end

  always_comb begin
    nxt = state;
    unique case (state)
      ST_IDLE:  if (any_req) nxt = ST_ISSUE;
      ST_ISSUE: nxt = took ? ST_OWN : ST_IDLE;
      ST_OWN:   if (rel_hit) nxt = ST_GAP;
      ST_GAP:   nxt = ST_IDLE;
      default:  nxt = ST_IDLE;
    endcase
  end

  assign head        = (state == ST_ISSUE);
  assign busy        = occupies_bus(state);
  assign evt_drop    = head & ~took;
  assign evt_release = (state == ST_OWN) & rel_hit;
endmodule

// File: rtl/dca_owner.sv
module dca_owner #(
  parameter int unsigned NDEV = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            load,
  input  logic [NDEV-1:0] take,
  input  logic            clear,
  output logic [NDEV-1:0] owner
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     owner <= '0;
    else if (load)  owner <= take;
    else if (clear) owner <= '0;
  end
endmodule

// File: rtl/chain_grant_arbiter.sv
module chain_grant_arbiter #(
  parameter int unsigned NDEV = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NDEV-1:0] req_i,
  input  logic [NDEV-1:0] rel_i,
  output logic [NDEV-1:0] gnt_o,
  output logic            busy_o
);
  logic            any_req;
  logic            head;
  logic [NDEV-1:0] take;
  logic            tail;
  logic            took;
  logic            rel_hit;
  logic            evt_issue;
  logic            evt_drop;
  logic            evt_release;
  logic [NDEV-1:0] owner;

  // Shared request line: OR of every master's request.
  assign any_req = |req_i;
  // Only the current owner's release pulse counts.
  assign rel_hit = |(rel_i & owner);
  assign took    = |take;

  dca_chain #(.NDEV(NDEV)) u_chain (
    .head (head),
    .want (req_i),
    .take (take),
    .tail (tail)
  );

  dca_ctrl u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .any_req     (any_req),
    .took        (took),
    .rel_hit     (rel_hit),
    .head        (head),
    .busy        (busy_o),
    .evt_drop    (evt_drop),
    .evt_release (evt_release)
  );

  assign evt_issue = head & took;

  dca_owner #(.NDEV(NDEV)) u_owner (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (evt_issue),
    .take  (take),
    .clear (evt_release),
    .owner (owner)
  );

  assign gnt_o = owner;
endmodule

// File: rtl/dca_checker.sv
module dca_checker #(
  parameter int unsigned NDEV = 4
) (
  input logic            clk,
  input logic            rst_n,
  input logic [NDEV-1:0] req_i,
  input logic [NDEV-1:0] rel_i,
  input logic [NDEV-1:0] gnt_o,
  input logic            busy_o,
  input logic            tail,
  input logic            evt_drop
);
  logic [NDEV-1:0] req_q;
  logic [NDEV-1:0] gnt_q;
  logic [NDEV-1:0] fresh;
  logic [NDEV-1:0] lowest_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_q <= '0;
      gnt_q <= '0;
    end else begin
      req_q <= req_i;
      gnt_q <= gnt_o;
    end
  end

  assign fresh    = gnt_o & ~gnt_q;
  assign lowest_q = req_q & (~req_q + {{(NDEV-1){1'b0}}, 1'b1});

  assert_single_owner_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(gnt_o));

  assert_lowest_wins_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (fresh != '0) |-> (gnt_o == lowest_q));

  assert_tenure_held_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ((gnt_o != '0) && ((rel_i & gnt_o) == '0)) |=> $stable(gnt_o));

  assert_release_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ((gnt_o & rel_i) != '0) |=> ((gnt_o == '0) && busy_o));

  assert_gap_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ((gnt_q != '0) && (gnt_o == '0)) |=> (gnt_o == '0));

  assert_busy_covers_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (gnt_o != '0) |-> busy_o);

  assert_drop_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    evt_drop |-> tail ##1 ((gnt_o == '0) && !busy_o));
endmodule

bind chain_grant_arbiter dca_checker #(.NDEV(NDEV)) u_dca_checker (
  .clk      (clk),
  .rst_n    (rst_n),
  .req_i    (req_i),
  .rel_i    (rel_i),
  .gnt_o    (gnt_o),
  .busy_o   (busy_o),
  .tail     (tail),
  .evt_drop (evt_drop)
);

// File: tb/sim_chain_grant_arbiter.sv
`timescale 1ns/1ps
module sim_chain_grant_arbiter;
  localparam int N = 4;

  logic         clk = 1'b0;
  logic         rst_n;
  logic [N-1:0] req_i;
  logic [N-1:0] rel_i;
  logic [N-1:0] gnt_o;
  logic         busy_o;

  int errs   = 0;
  int checks = 0;
  int cyc    = 0;
  int exp_q[$];
  logic [N-1:0] prev_gnt;
  bit saw_last = 1'b0;

  always #10 clk = ~clk;

  chain_grant_arbiter #(.NDEV(N)) u0 (
    .clk    (clk),
    .rst_n  (rst_n),
    .req_i  (req_i),
    .rel_i  (rel_i),
    .gnt_o  (gnt_o),
    .busy_o (busy_o)
  );

  function automatic int vec_index(input logic [N-1:0] v);
    int r = -1;
    for (int i = N - 1; i >= 0; i--) if (v[i]) r = i;
    return r;
  endfunction

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errs++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  endtask

  // Monitor: compare each new tenure against the scoreboard.
  always @(negedge clk) begin
    if (!rst_n) prev_gnt <= '0;
    else begin
      if (gnt_o != '0 && prev_gnt == '0) begin
        if (gnt_o[N-1]) saw_last = 1'b1;
        if (exp_q.size() == 0) check("R2 unexpected grant", vec_index(gnt_o), -1);
        else check("R2 scoreboard winner", vec_index(gnt_o), exp_q.pop_front());
      end
      prev_gnt <= gnt_o;
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      check("watchdog", 1, 0);
      finish_run();
    end
  end

  initial begin
    req_i = '0; rel_i = '0; rst_n = 1'b0;
    tick(3);
    check("R10 reset gnt", int'(gnt_o), 0);
    check("R10 reset busy", int'(busy_o), 0);
    rst_n = 1'b1;
    tick(1);
    check("R10 after reset gnt", int'(gnt_o), 0);
    check("R10 after reset busy", int'(busy_o), 0);

    // R3: single request on idle bus
    exp_q.push_back(2);
    req_i = 4'b0100;
    tick(1);
    check("R3 no grant after sampling edge", int'(gnt_o), 0);
    tick(1);
    check("R3 grant on second edge", int'(gnt_o), 4);
    check("R7 busy while owned", int'(busy_o), 1);

    // R4: higher priority request during tenure
    req_i = 4'b0101;
    tick(3);
    check("R4 owner kept vs higher req", int'(gnt_o), 4);
    req_i = 4'b0001;
    tick(1);
    check("R4 owner kept after own req drop", int'(gnt_o), 4);
    // R5: non-owner release ignored
    rel_i = 4'b0001;
    tick(1);
    rel_i = '0;
    check("R5 foreign release ignored", int'(gnt_o), 4);
    check("R5 busy stays", int'(busy_o), 1);

    // R6: owner release and gap
    exp_q.push_back(0);
    rel_i = 4'b0100;
    tick(1);
    rel_i = '0;
    check("R6 grant gone after release", int'(gnt_o), 0);
    check("R7 busy in gap cycle", int'(busy_o), 1);
    tick(1);
    check("R6 still no grant", int'(gnt_o), 0);
    check("R7 busy low after gap", int'(busy_o), 0);
    tick(1);
    check("R6 issue cycle no grant yet", int'(gnt_o), 0);
    tick(1);
    check("R2 device 0 wins", int'(gnt_o), 1);

    // R2: release coincides with new pattern of requesters
    exp_q.push_back(1);
    req_i = 4'b1010;
    rel_i = 4'b0001;
    tick(1);
    rel_i = '0;
    tick(3);
    check("R2 lowest of 1 and 3", int'(gnt_o), 2);

    // R8: request withdrawn before issue cycle
    req_i = '0;
    rel_i = 4'b0010;
    tick(1);
    rel_i = '0;
    tick(1);
    req_i = 4'b1000;
    tick(1);
    req_i = '0;
    tick(1);
    check("R8 dropped grant", int'(gnt_o), 0);
    check("R8 bus idle", int'(busy_o), 0);
    tick(2);
    check("R8 still idle", int'(gnt_o), 0);

    // R9: starvation of the tail
    exp_q.push_back(0);
    req_i = 4'b1001;
    tick(2);
    check("R9 head owns", int'(gnt_o), 1);
    for (int r = 0; r < 4; r++) begin
      exp_q.push_back(0);
      rel_i = 4'b0001;
      tick(1);
      rel_i = '0;
      tick(3);
      check("R9 head regains", int'(gnt_o), 1);
    end
    check("R9 tail starved", int'(saw_last), 0);

    // R2: tail reachable once head stops
    exp_q.push_back(N - 1);
    req_i = 4'b1000;
    rel_i = 4'b0001;
    tick(1);
    rel_i = '0;
    tick(3);
    check("R2 tail granted", int'(gnt_o), 8);
    req_i = '0;
    rel_i = 4'b1000;
    tick(1);
    rel_i = '0;
    tick(4);
    check("R1 idle end", int'(gnt_o), 0);
    check("R2 scoreboard drained", exp_q.size(), 0);
    finish_run();
  end
endmodule